// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's execution pipeline and its private L1 data cache. Each store is queued with a word address, data and byte enables. The queue writes stores to the cache one at a time, in the order they arrived. A store stays private to the owning core until the cache write port accepts it. While a store waits in the queue, loads from the same core can already read its bytes. A load does not wait for queued stores to unrelated addresses.

A load looks up the queue in the cycle it is presented. For each byte it asks for, the load takes that byte from the youngest queued store that writes it. Bytes that no queued store writes come from the cache read data, which the core supplies in the same cycle. The merged result is returned one cycle later. Some overlaps cannot be merged: the load and a queued store share some bytes, but each also has bytes the other lacks. In that case the load is held off until that store has left the queue.

An atomic read-modify-write starts by closing the store port. The block then waits until every older store has reached the cache. Next it takes a lock on the target line and signals the core that it may perform the atomic's load. The atomic's store data enters the now-empty queue. The lock is released in the same cycle the cache accepts that store.

Top module: `st_queue_fwd`

## Requirements
- R1: Stores are written to the cache in exactly the order they were accepted, and one store leaves per cycle in which `cw_valid` and `cw_ready` are both high. While `cw_ready` is low, the presented address, data and byte enables stay unchanged.
- R2: `cw_valid` is high exactly when the queue holds at least one store. A store leaves the queue only on a cache write handshake.
- R3: A load accepted in cycle N returns data in cycle N+1 with `ld_rsp_valid` high. Each byte i enabled by `ld_be[i]` (covering data bits 8i+7..8i) comes from the youngest queued store to the same address with that byte enabled, or else from `ld_cache_data`. Bytes not enabled in `ld_be` read as zero.
- R4: A queued store whose byte enables lie entirely inside a wider load is merged into that load, and the other bytes come from the cache data.
- R5: If a queued store to the load's address shares at least one byte with the load, and each of them also has a byte the other lacks, `ld_ready` is low.
- R6: With no such partial overlap, `ld_ready` is high, even when older stores to other addresses are still queued.
- R7: An atomic request closes the store port from the next cycle on. A store accepted in the same cycle as the request counts as older. `at_go` pulses only after every older store has been written to the cache.
- R8: `lock_hold` rises together with `at_go`, with `lock_addr` equal to the requested address. It stays high and stable until the cache accepts the atomic's store, which is written to `lock_addr`, and it is low in the following cycle.
- R9: The queue holds DEPTH (8) stores. When it is full, `st_ready` is low and no queued store is overwritten.
- R10: Reset empties the queue, drops any held lock, and clears the load response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store enqueue request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_ready | output | 1 | Load accepted (low on an unmergeable overlap) |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Load byte enables |
| ld_cache_data | input | DW | Cache read data for ld_addr, same cycle |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | DW | Merged load result |
| cw_valid | output | 1 | Cache write request (head of queue) |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| cw_be | output | DW/8 | Cache write byte enables |
| at_req | input | 1 | Atomic read-modify-write request |
| at_addr | input | AW | Atomic target address |
| at_go | output | 1 | Pulse: atomic load may be performed |
| at_st_valid | input | 1 | Atomic store data presented after at_go |
| at_st_data | input | DW | Atomic store data |
| at_st_be | input | DW/8 | Atomic store byte enables |
| lock_hold | output | 1 | Line ownership must be kept |
| lock_addr | output | AW | Locked line address |

## Verification
Two events can fall in one cycle here. First, a load can hit a queued store in the very cycle the cache accepts that store. Random traffic over four addresses, with `cw_ready` toggled at random, makes this happen often. The reference model evaluates the load against the queue and cache contents as they stand before the handshake, so the forwarded bytes must still come from the departing entry. Second, a store enqueue can coincide with an atomic request. A directed sequence drives both together. The bench then judges that the store is accepted, that it is written to the cache before `at_go`, and that `st_ready` stays low from the next cycle until the lock is released.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  typedef enum logic [1:0] {
    AT_IDLE,
    AT_DRAIN,
    AT_LOCKED,
    AT_COMMIT
  } at_state_e;
endpackage

// File: rtl/sbq_store_ram.sv
module sbq_store_ram #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [AW-1:0]          push_addr,
  input  logic [DW-1:0]          push_data,
  input  logic [DW/8-1:0]        push_be,
  input  logic                   pop,
  output logic                   full,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] occ,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [AW-1:0]          ent_addr [DEPTH],
  output logic [DW-1:0]          ent_data [DEPTH],
  output logic [DW/8-1:0]        ent_be   [DEPTH]
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = DW / 8;

  logic [PW-1:0] wr_ptr;
  logic [AW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic [BW-1:0] mem_be   [DEPTH];

  // storage written without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem_addr[wr_ptr] <= push_addr;
      mem_data[wr_ptr] <= push_data;
      mem_be[wr_ptr]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == (PW+1)'(DEPTH));
  assign empty = (occ == '0);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      assign ent_addr[g] = mem_addr[g];
      assign ent_data[g] = mem_data[g];
      assign ent_be[g]   = mem_be[g];
    end
  endgenerate
endmodule

// File: rtl/sbq_fwd.sv
module sbq_fwd #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [AW-1:0]            ent_addr [DEPTH],
  input  logic [DW-1:0]            ent_data [DEPTH],
  input  logic [DW/8-1:0]          ent_be   [DEPTH],
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  input  logic [$clog2(DEPTH):0]   occ,
  input  logic [AW-1:0]            ld_addr,
  input  logic [DW/8-1:0]          ld_be,
  input  logic [DW-1:0]            cache_data,
  output logic [DW-1:0]            fwd_data,
  output logic                     conflict
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = DW / 8;

  always_comb begin
    logic [PW-1:0] idx;
    logic          hit;
    logic [BW-1:0] sbe;
    fwd_data = cache_data;
    conflict = 1'b0;
    // walk oldest to youngest so younger stores win each byte
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr + PW'(k);
      hit = ((PW+1)'(k) < occ) && (ent_addr[idx] == ld_addr);
      sbe = ent_be[idx];
      if (hit) begin
        for (int b = 0; b < BW; b++) begin
          if (sbe[b]) fwd_data[8*b +: 8] = ent_data[idx][8*b +: 8];
        end
        if (((sbe & ld_be) != '0) && ((sbe & ~ld_be) != '0) &&
            ((ld_be & ~sbe) != '0))
          conflict = 1'b1;
      end
    end
    for (int b = 0; b < BW; b++) begin
      if (!ld_be[b]) fwd_data[8*b +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/sbq_atomic_ctl.sv
module sbq_atomic_ctl
  import sbq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          at_req,
  input  logic [AW-1:0] at_addr,
  input  logic          buf_empty,
  input  logic          pop,
  input  logic          at_st_valid,
  output logic          enq_open,
  output logic          at_push,
  output logic          at_go,
  output logic          lock_hold,
  output logic [AW-1:0] lock_addr
);
  at_state_e state;

  assign enq_open = (state == AT_IDLE);
  assign at_push  = (state == AT_LOCKED) && at_st_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= AT_IDLE;
      at_go     <= 1'b0;
      lock_hold <= 1'b0;
      lock_addr <= '0;
    end else begin
      at_go <= 1'b0;
      case (state)
        AT_IDLE: if (at_req) begin
          lock_addr <= at_addr;
          state     <= AT_DRAIN;
        end
        AT_DRAIN: if (buf_empty) begin
          state     <= AT_LOCKED;
          lock_hold <= 1'b1;
          at_go     <= 1'b1;
        end
        AT_LOCKED: if (at_st_valid) state <= AT_COMMIT;
        AT_COMMIT: if (pop) begin
          state     <= AT_IDLE;
          lock_hold <= 1'b0;
        end
        default: state <= AT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/st_queue_fwd.sv
module st_queue_fwd #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW/8-1:0] ld_be,
  input  logic [DW-1:0]   ld_cache_data,
  output logic            ld_rsp_valid,
  output logic [DW-1:0]   ld_rsp_data,
  output logic            cw_valid,
  input  logic            cw_ready,
  output logic [AW-1:0]   cw_addr,
  output logic [DW-1:0]   cw_data,
  output logic [DW/8-1:0] cw_be,
  input  logic            at_req,
  input  logic [AW-1:0]   at_addr,
  output logic            at_go,
  input  logic            at_st_valid,
  input  logic [DW-1:0]   at_st_data,
  input  logic [DW/8-1:0] at_st_be,
  output logic            lock_hold,
  output logic [AW-1:0]   lock_addr
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = DW / 8;

  logic          full, empty, enq_open, at_push, push, pop, conflict;
  logic [PW:0]   occ;
  logic [PW-1:0] rd_ptr;
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [BW-1:0] ent_be   [DEPTH];
  logic [DW-1:0] fwd_data;

  assign st_ready = enq_open && !full;
  assign push     = (st_valid && st_ready) || at_push;
  assign cw_valid = !empty;
  assign pop      = cw_valid && cw_ready;
  assign cw_addr  = ent_addr[rd_ptr];
  assign cw_data  = ent_data[rd_ptr];
  assign cw_be    = ent_be[rd_ptr];
  assign ld_ready = !conflict;

  sbq_store_ram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (at_push ? lock_addr : st_addr),
    .push_data (at_push ? at_st_data : st_data),
    .push_be   (at_push ? at_st_be : st_be),
    .pop       (pop),
    .full      (full),
    .empty     (empty),
    .occ       (occ),
    .rd_ptr    (rd_ptr),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_be    (ent_be)
  );

  sbq_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .ent_addr   (ent_addr),
    .ent_data   (ent_data),
    .ent_be     (ent_be),
    .rd_ptr     (rd_ptr),
    .occ        (occ),
    .ld_addr    (ld_addr),
    .ld_be      (ld_be),
    .cache_data (ld_cache_data),
    .fwd_data   (fwd_data),
    .conflict   (conflict)
  );

  sbq_atomic_ctl #(.AW(AW)) u_atom (
    .clk         (clk),
    .rst         (rst),
    .at_req      (at_req),
    .at_addr     (at_addr),
    .buf_empty   (empty),
    .pop         (pop),
    .at_st_valid (at_st_valid),
    .enq_open    (enq_open),
    .at_push     (at_push),
    .at_go       (at_go),
    .lock_hold   (lock_hold),
    .lock_addr   (lock_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rsp_valid <= 1'b0;
      ld_rsp_data  <= '0;
    end else begin
      ld_rsp_valid <= ld_valid && ld_ready;
      if (ld_valid && ld_ready) ld_rsp_data <= fwd_data;
    end
  end
endmodule

// File: rtl/sbq_chk.sv
module sbq_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   st_ready,
  input logic                   cw_valid,
  input logic                   cw_ready,
  input logic [AW-1:0]          cw_addr,
  input logic [DW-1:0]          cw_data,
  input logic [DW/8-1:0]        cw_be,
  input logic                   at_go,
  input logic                   lock_hold,
  input logic [AW-1:0]          lock_addr,
  input logic [$clog2(DEPTH):0] occ
);
  // R1
  cw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data) && $stable(cw_be));
  // R2
  leave_on_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (occ < $past(occ)) |-> $past(cw_valid && cw_ready));
  // R7
  go_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    at_go |-> (occ == '0) && !cw_valid);
  // R8
  go_locks_chk: assert property (@(posedge clk) disable iff (rst)
    at_go |-> lock_hold);
  // R8
  lock_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && lock_hold && $past(lock_hold) |-> $stable(lock_addr));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(DEPTH)+1)'(DEPTH));
  // R9
  full_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    occ == ($clog2(DEPTH)+1)'(DEPTH) |-> !st_ready);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst && $past(rst) |-> (occ == '0) && !lock_hold);
endmodule

bind st_queue_fwd sbq_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st_ready  (st_ready),
  .cw_valid  (cw_valid),
  .cw_ready  (cw_ready),
  .cw_addr   (cw_addr),
  .cw_data   (cw_data),
  .cw_be     (cw_be),
  .at_go     (at_go),
  .lock_hold (lock_hold),
  .lock_addr (lock_addr),
  .occ       (occ)
);

// File: tb/tb_st_queue_fwd.sv
module tb_st_queue_fwd;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst = 1;
  logic st_valid = 0, ld_valid = 0, cw_ready = 0, at_req = 0, at_st_valid = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0, at_addr = 0;
  logic [DW-1:0] st_data = 0, ld_cache_data = 0, at_st_data = 0;
  logic [BW-1:0] st_be = 0, ld_be = 0, at_st_be = 0;
  logic st_ready, ld_ready, ld_rsp_valid, cw_valid, at_go, lock_hold;
  logic [DW-1:0] ld_rsp_data, cw_data;
  logic [AW-1:0] cw_addr, lock_addr;
  logic [BW-1:0] cw_be;

  always #5 clk = ~clk;

  st_queue_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] cmem [16];
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];
  logic [BW-1:0] qb [$];
  bit pend = 0;
  logic [DW-1:0] pend_exp;
  bit at_busy = 0, at_push_now = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_load(input logic [AW-1:0] a, input logic [BW-1:0] be);
    logic [DW-1:0] r;
    r = cmem[a[3:0]];
    foreach (qa[i]) if (qa[i] == a)
      for (int b = 0; b < BW; b++) if (qb[i][b]) r[8*b +: 8] = qd[i][8*b +: 8];
    for (int b = 0; b < BW; b++) if (!be[b]) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  function automatic bit exp_conf(input logic [AW-1:0] a, input logic [BW-1:0] be);
    bit c = 0;
    foreach (qa[i]) if (qa[i] == a && (qb[i] & be) != 0 && (qb[i] & ~be) != 0 && (be & ~qb[i]) != 0) c = 1;
    return c;
  endfunction

  // one cycle: called at a falling edge, returns at the next falling edge
  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [BW-1:0] sb, input bit lv, input logic [AW-1:0] la,
                      input logic [BW-1:0] lb, input bit cr);
    bit ec;
    if (pend) chk(ld_rsp_valid && ld_rsp_data == pend_exp, "R3 load result", {31'd0, ld_rsp_valid, ld_rsp_data}, {32'd1, pend_exp});
    pend = 0;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    ld_valid = lv; ld_addr = la; ld_be = lb; ld_cache_data = cmem[la[3:0]];
    cw_ready = cr;
    #1;
    chk(cw_valid == (qa.size() != 0), "R2 cw_valid", cw_valid, qa.size() != 0);
    if (cw_valid && qa.size() != 0)
      chk(cw_addr == qa[0] && cw_data == qd[0] && cw_be == qb[0], "R1 commit order",
          {cw_addr, cw_data}, {qa[0], qd[0]});
    chk(st_ready == (!at_busy && qa.size() < DEPTH), at_busy ? "R7 port closed" : "R9 st_ready",
        st_ready, !at_busy && qa.size() < DEPTH);
    if (lv) begin
      ec = exp_conf(la, lb);
      chk(ld_ready == !ec, ec ? "R5 stall" : "R6 no stall", ld_ready, !ec);
      if (ld_ready) begin pend = 1; pend_exp = exp_load(la, lb); end
    end
    if (cw_valid && cw_ready && qa.size() != 0) begin
      for (int b = 0; b < BW; b++) if (qb[0][b]) cmem[qa[0][3:0]][8*b +: 8] = qd[0][8*b +: 8];
      void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
    end
    if (sv && st_ready) begin qa.push_back(sa); qd.push_back(sd); qb.push_back(sb); end
    if (at_push_now) begin qa.push_back(at_addr); qd.push_back(at_st_data); qb.push_back(at_st_be); end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; st_valid = 0; ld_valid = 0; cw_ready = 0; at_req = 0; at_st_valid = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    chk(!cw_valid && !lock_hold && st_ready && !ld_rsp_valid, "R10 reset state",
        {cw_valid, lock_hold, st_ready, ld_rsp_valid}, 4'b0010);
    qa.delete(); qd.delete(); qb.delete();
    pend = 0; at_busy = 0; at_push_now = 0;
  endtask

  task automatic atomic_seq(input bit abort);
    bit got = 0;
    for (int i = 0; i < 3; i++) step(1, AW'(i), $urandom, 4'hF, 0, 0, 0, 0);
    at_req = 1; at_addr = 16'd2;
    step(1, 16'd2, 32'hA5A5_0001, 4'h3, 0, 0, 0, 0);
    chk(qa.size() == 4, "R7 same-cycle store accepted", qa.size(), 4);
    at_req = 0; at_busy = 1;
    step(1, 16'd1, 32'h1, 4'hF, 1, 16'd2, 4'hF, 0);
    step(1, 16'd1, 32'h1, 4'hF, 0, 0, 0, 0);
    for (int i = 0; i < 40 && !got; i++) begin
      if (at_go) begin
        chk(qa.size() == 0, "R7 drained before go", qa.size(), 0);
        chk(lock_hold && lock_addr == 16'd2, "R8 lock at go", {lock_hold, lock_addr}, {1'b1, 16'd2});
        got = 1;
      end else begin
        chk(!lock_hold, "R8 no lock before go", lock_hold, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
      end
    end
    chk(got, "R7 go seen", got, 1);
    at_st_valid = 1; at_st_data = 32'hC0DE_0042; at_st_be = 4'hF; at_push_now = 1;
    step(0, 0, 0, 0, 1, 16'd2, 4'hF, 0);
    at_st_valid = 0; at_push_now = 0;
    if (abort) begin
      do_reset();
      return;
    end
    step(0, 0, 0, 0, 1, 16'd2, 4'h1, 0);
    chk(lock_hold, "R8 lock held until commit", lock_hold, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk(!lock_hold, "R8 lock released", lock_hold, 0);
    at_busy = 0;
    step(0, 0, 0, 0, 1, 16'd2, 4'hF, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) cmem[i] = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cw_valid && !lock_hold && st_ready && !ld_rsp_valid, "R10 initial reset",
        {cw_valid, lock_hold, st_ready, ld_rsp_valid}, 4'b0010);
    rst = 0;
    // directed: narrow store inside wide load
    step(1, 16'd1, 32'h0000_BB00, 4'b0010, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'd1, 4'hF, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(ld_rsp_data == {cmem[1][31:16], 8'hBB, cmem[1][7:0]}, "R4 merge", ld_rsp_data,
        {cmem[1][31:16], 8'hBB, cmem[1][7:0]});
    // directed: partial overlap stalls, unrelated address does not
    step(1, 16'd3, 32'h1234_5678, 4'b0011, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'd3, 4'b0110, 0);
    chk(!ld_ready, "R5 partial overlap stall", ld_ready, 0);
    step(0, 0, 0, 0, 1, 16'd0, 4'hF, 0);
    chk(ld_ready, "R6 other address proceeds", ld_ready, 1);
    // directed: fill to capacity
    for (int i = 0; i < DEPTH + 2; i++) step(1, AW'(i % 4), $urandom, 4'hF, 0, 0, 0, 0);
    chk(!st_ready && qa.size() == DEPTH, "R9 full", {st_ready, 8'(qa.size())}, {1'b0, 8'(DEPTH)});
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, AW'(i % 4), 4'hF, 1);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      bit cr;
      cr = ((c % 200) < 20) ? 1'b0 : ($urandom_range(0, 2) != 0);
      step($urandom_range(0, 1), AW'($urandom_range(0, 3)), $urandom, BW'($urandom_range(1, 15)),
           $urandom_range(0, 1), AW'($urandom_range(0, 3)), BW'($urandom_range(1, 15)), cr);
    end
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    atomic_seq(0);
    atomic_seq(1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    atomic_seq(0);
    finish_run();
  end
endmodule